// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B. Each transfer direction has its own holding register, its own rising-edge capture clock, its own source select and its own output enable. For each direction the select chooses what goes onto the far bus. It can pass the near bus's live input straight through, or it can send the value held in that direction's register.

Each bus is modelled as three separate signals: an input vector, an output vector and an output-enable. This keeps the block synthesizable. Combining the drivers on the real bus is left to the surrounding logic or the testbench. Both directions may drive at the same time.

Inside the block, a bus's value is the block's own drive when the block is driving that bus, and the external input otherwise. A capture edge always samples that value. The output enables never block a capture. For each bus, a contention flag rises while the block drives that bus and an external driver reports that it is also driving it.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `clk_ab`, the A-to-B register loads the A bus value. When `ab_use_stored` is 1, `b_out` shows the value loaded at the most recent `clk_ab` edge.
- R2: On every rising edge of `clk_ba`, the B-to-A register loads the B bus value. When `ba_use_stored` is 1, `a_out` shows the value loaded at the most recent `clk_ba` edge.
- R3: Captures happen whatever the enables are. In isolation (`ab_drive_en`=0 and `ba_drive_n`=1), both registers still load on their clock edges.
- R4: `b_oe` equals `ab_drive_en`, which is active high. `a_oe` equals the inverse of `ba_drive_n`, which is active low.
- R5: When `ab_use_stored` is 0, `b_out` equals `a_in` in the same cycle, with no register in the path.
- R6: When `ba_use_stored` is 0, `a_out` equals `b_in` in the same cycle, with no register in the path.
- R7: The bus value that a register captures is the block's own output for that bus when the block is driving it, and the bus input otherwise. So with B driven from live A, a `clk_ba` edge loads `a_in` into the B-to-A register.
- R8: `a_clash` is 1 exactly when `a_oe` and `a_ext` are both 1. `b_clash` is 1 exactly when `b_oe` and `b_ext` are both 1.
- R9: A synchronous active-high `rst`, sampled on each register's own clock, clears that register to zero.
- R10: With both enables active and both selects at 1, each bus carries the other direction's stored value. A simultaneous edge on both clocks then swaps the two register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Value driven onto bus A from outside |
| a_out | output | WIDTH | Value the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| b_in | input | WIDTH | Value driven onto bus B from outside |
| b_out | output | WIDTH | Value the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |
| ab_use_stored | input | 1 | 1: B carries stored A-to-B value; 0: live A |
| ba_use_stored | input | 1 | 1: A carries stored B-to-A value; 0: live B |
| ab_drive_en | input | 1 | Active-high enable for driving bus B |
| ba_drive_n | input | 1 | Active-low enable for driving bus A |
| a_ext | input | 1 | An outside driver is also driving bus A |
| b_ext | input | 1 | An outside driver is also driving bus B |
| a_clash | output | 1 | Contention on bus A |
| b_clash | output | 1 | Contention on bus B |

## Verification
Three pairs of functions can fall in the same cycle.

- **Capture while driving.** A capture can land while the block is driving the bus it samples. The bench enables live A onto B and pulses only `clk_ba`. It then switches the B-to-A select to stored and expects `a_out` to show the A input, not the different value held on `b_in`.
- **Both clocks together.** Both clocks can rise together while each bus carries the other direction's stored value. The bench expects the two registers to exchange contents.
- **Clock edge while isolated.** A clock edge can arrive while both enables are off. The bench checks that the outputs are disabled, then selects stored data and compares both outputs with the values presented at that edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int XCVR_DEFAULT_WIDTH = 8;

    // Per-direction control word
    typedef struct packed {
        logic use_stored;  // 1: drive stored value, 0: pass live input
        logic oe_raw;      // enable as seen at the pin, before polarity
        logic ext_drive;   // an outside driver claims the far bus
    } lane_ctrl_t;

    // Bring an enable pin of either polarity to active high
    function automatic logic enable_level(input logic raw, input bit active_low);
        return active_low ? ~raw : raw;
    endfunction

endpackage

// File: rtl/bus_view.sv
module bus_view #(
    parameter int WIDTH = xcvr_pkg::XCVR_DEFAULT_WIDTH
) (
    input  logic             self_oe,
    input  logic [WIDTH-1:0] self_drive,
    input  logic [WIDTH-1:0] outside,
    output logic [WIDTH-1:0] level
);
    // The block's own drive wins on the bus while it is enabled
    assign level = self_oe ? self_drive : outside;
endmodule

// File: rtl/xfer_lane.sv
module xfer_lane
    import xcvr_pkg::*;
#(
    parameter int WIDTH      = XCVR_DEFAULT_WIDTH,
    parameter bit OE_ACT_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cap_d,    // resolved value of the source bus
    input  logic [WIDTH-1:0] live_d,   // outside input of the source bus
    input  lane_ctrl_t       ctrl,
    output logic [WIDTH-1:0] q_out,
    output logic             oe,
    output logic             clash
);
    logic [WIDTH-1:0] held_q;

    // Loads on every edge, whatever the enable is doing
    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= cap_d;
    end

    assign q_out = ctrl.use_stored ? held_q : live_d;
    assign oe    = enable_level(ctrl.oe_raw, OE_ACT_LOW);
    assign clash = oe & ctrl.ext_drive;

    // R1 / R2: stored output reflects the value present at the previous edge
    assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ctrl.use_stored) |-> (q_out == $past(cap_d)));

    // R9: a reset edge leaves zero behind
    assert_reset_zero_R9: assert property (@(posedge clk)
        ($past(rst) && ctrl.use_stored) |-> (q_out == '0));

    // R5 / R6: live path bypasses the register
    assert_live_path_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl.use_stored |-> (q_out == live_d));

    // R8: no clash without both an own and an outside driver
    assert_clash_cause_R8: assert property (@(posedge clk) disable iff (rst)
        clash |-> (oe && ctrl.ext_drive));
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int WIDTH = XCVR_DEFAULT_WIDTH
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_use_stored,
    input  logic             ba_use_stored,
    input  logic             ab_drive_en,
    input  logic             ba_drive_n,
    input  logic             a_ext,
    input  logic             b_ext,
    output logic             a_clash,
    output logic             b_clash
);
    localparam int NUM_BUS = 2;

    lane_ctrl_t       ctl_ab, ctl_ba;
    logic [WIDTH-1:0] bus_lvl  [NUM_BUS];
    logic [WIDTH-1:0] self_drv [NUM_BUS];
    logic [WIDTH-1:0] outside  [NUM_BUS];
    logic             self_oe  [NUM_BUS];

    assign ctl_ab = '{use_stored: ab_use_stored, oe_raw: ab_drive_en, ext_drive: b_ext};
    assign ctl_ba = '{use_stored: ba_use_stored, oe_raw: ba_drive_n,  ext_drive: a_ext};

    // index 0 = bus A, index 1 = bus B
    assign self_drv[0] = a_out;  assign self_oe[0] = a_oe;  assign outside[0] = a_in;
    assign self_drv[1] = b_out;  assign self_oe[1] = b_oe;  assign outside[1] = b_in;

    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
        bus_view #(.WIDTH(WIDTH)) u_view (
            .self_oe   (self_oe[g]),
            .self_drive(self_drv[g]),
            .outside   (outside[g]),
            .level     (bus_lvl[g])
        );
    end

    xfer_lane #(.WIDTH(WIDTH), .OE_ACT_LOW(1'b0)) u_lane_ab (
        .clk(clk_ab), .rst(rst), .cap_d(bus_lvl[0]), .live_d(a_in),
        .ctrl(ctl_ab), .q_out(b_out), .oe(b_oe), .clash(b_clash)
    );

    xfer_lane #(.WIDTH(WIDTH), .OE_ACT_LOW(1'b1)) u_lane_ba (
        .clk(clk_ba), .rst(rst), .cap_d(bus_lvl[1]), .live_d(b_in),
        .ctrl(ctl_ba), .q_out(a_out), .oe(a_oe), .clash(a_clash)
    );

    // R3 / R4: isolation code leaves both buses undriven
    assert_isolation_R4: assert property (@(posedge clk_ab) disable iff (rst)
        (!ab_drive_en && ba_drive_n) |-> (!a_oe && !b_oe));

    // R7: while B is driven from live A, the B-to-A register samples A
    assert_drive_capture_R7: assert property (@(posedge clk_ba) disable iff (rst)
        (!$past(rst) && $past(b_oe) && !$past(ab_use_stored) && ba_use_stored)
        |-> (a_out == $past(a_in)));
endmodule

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;
    localparam int W = 8;

    logic clk = 1'b0;
    logic gate_ab = 1'b0, gate_ba = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe, a_clash, b_clash;
    logic ab_use_stored = 1'b0, ba_use_stored = 1'b0;
    logic ab_drive_en = 1'b0, ba_drive_n = 1'b1;
    logic a_ext = 1'b0, b_ext = 1'b0;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;  // 125 MHz
    wire clk_ab = clk & gate_ab;
    wire clk_ba = clk & gate_ba;

    bus_xcvr_reg #(.WIDTH(W)) i_bus_xcvr_reg (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_use_stored(ab_use_stored), .ba_use_stored(ba_use_stored),
        .ab_drive_en(ab_drive_en), .ba_drive_n(ba_drive_n),
        .a_ext(a_ext), .b_ext(b_ext), .a_clash(a_clash), .b_clash(b_clash)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one edge on the chosen clocks; returns just after the falling edge
    task automatic pulse(input logic do_ab, input logic do_ba);
        @(negedge clk); gate_ab = do_ab; gate_ba = do_ba;
        @(negedge clk); gate_ab = 1'b0; gate_ba = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        @(negedge clk); rst = 1'b1; gate_ab = 1'b1; gate_ba = 1'b1;
        a_in = 8'hFF; b_in = 8'hEE;
        repeat (2) @(negedge clk);
        gate_ab = 1'b0; gate_ba = 1'b0; rst = 1'b0;
        ab_use_stored = 1'b1; ba_use_stored = 1'b1; #1;
        check("R9 b_out after reset", b_out, 8'h00);
        check("R9 a_out after reset", a_out, 8'h00);
    endtask

    task automatic t_live;
        @(negedge clk); ab_use_stored = 0; ba_use_stored = 0;
        a_in = 8'h5A; b_in = 8'hC3; #1;
        check("R5 live A to B", b_out, 8'h5A);
        check("R6 live B to A", a_out, 8'hC3);
        a_in = 8'h0F; #1;
        check("R5 live follows input", b_out, 8'h0F);
    endtask

    task automatic t_isolation;
        @(negedge clk); ab_drive_en = 0; ba_drive_n = 1; #1;
        check("R4 b_oe off in isolation", {7'd0, b_oe}, 8'd0);
        check("R4 a_oe off in isolation", {7'd0, a_oe}, 8'd0);
        a_in = 8'h11; b_in = 8'h22;
        pulse(1, 1);
        ab_use_stored = 1; ba_use_stored = 1; a_in = 8'h99; b_in = 8'h88; #1;
        check("R3 AB captured while isolated", b_out, 8'h11);
        check("R3 BA captured while isolated", a_out, 8'h22);
    endtask

    task automatic t_separate_clocks;
        a_in = 8'h33; pulse(1, 0);
        check("R1 AB loads on its clock", b_out, 8'h33);
        check("R2 BA holds without its clock", a_out, 8'h22);
        b_in = 8'h44; pulse(0, 1);
        check("R2 BA loads on its clock", a_out, 8'h44);
        check("R1 AB holds without its clock", b_out, 8'h33);
    endtask

    task automatic t_drive_capture;
        @(negedge clk); ab_drive_en = 1; ab_use_stored = 0; ba_drive_n = 1;
        a_in = 8'h77; b_in = 8'h99; #1;
        check("R4 b_oe follows active-high enable", {7'd0, b_oe}, 8'd1);
        pulse(0, 1);
        ba_use_stored = 1; #1;
        check("R7 BA register took driven B value", a_out, 8'h77);
    endtask

    task automatic t_both_stored;
        // make AB hold 0x12 and BA hold 0x34 with no driving
        @(negedge clk); ab_drive_en = 0; ba_drive_n = 1;
        a_in = 8'h12; b_in = 8'h34; pulse(1, 1);
        ab_use_stored = 1; ba_use_stored = 1; ab_drive_en = 1; ba_drive_n = 0; #1;
        check("R4 a_oe follows active-low enable", {7'd0, a_oe}, 8'd1);
        check("R10 stored A on B", b_out, 8'h12);
        check("R10 stored B on A", a_out, 8'h34);
        a_in = 8'hAA; b_in = 8'hBB;
        pulse(1, 1);
        check("R10 swap into AB", b_out, 8'h34);
        check("R10 swap into BA", a_out, 8'h12);
    endtask

    task automatic t_clash;
        @(negedge clk); ab_drive_en = 1; ba_drive_n = 0; a_ext = 1; b_ext = 0; #1;
        check("R8 A clash raised", {7'd0, a_clash}, 8'd1);
        check("R8 B clash quiet", {7'd0, b_clash}, 8'd0);
        ba_drive_n = 1; b_ext = 1; #1;
        check("R8 A clash needs own drive", {7'd0, a_clash}, 8'd0);
        check("R8 B clash raised", {7'd0, b_clash}, 8'd1);
        a_ext = 0; b_ext = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_live();
        t_isolation();
        t_separate_clocks();
        t_drive_capture();
        t_both_stored();
        t_clash();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule